// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block keeps a 32-bit software-loadable instruction counter and a small level threshold register. It sits next to the retire stage. Each valid instruction is counted only when it runs at an interrupt level below the threshold. Software arms a single-step or N-step trap by loading a negative count. For example, -2 traps on the second counted instruction.

The trigger fires before the instruction executes, not after it. When a counted instruction finds the counter at all-ones, the block raises `req_o` in that same cycle, so the pipeline can turn the instruction into a debug exception. The counter then wraps to zero. The request also passes the usual debug gate: the current level must be below the debug level. Taking the exception and capturing the PC are handled outside this block.

Top module: `icnt_trigger`

## Requirements
- R1: After asynchronous reset the counter and the threshold are 0 and `req_o` is low.
- R2: A write with `wr_sel_i`=0 loads the counter from `wr_data_i`. A write with `wr_sel_i`=1 loads the threshold from the low `LVL_W` bits. Either write takes effect at the next clock edge.
- R3: A valid instruction whose level is strictly below the threshold increments the counter by one at the next edge. A threshold of 0 counts nothing.
- R4: A valid instruction at or above the threshold leaves the counter unchanged and never raises `req_o`.
- R5: `req_o` is high in the same cycle when all three hold: a counted instruction is present, the counter is all-ones, and the level is below `DBG_LEVEL` (default 6).
- R6: When `req_o` fires, the counter becomes 0 at the next edge.
- R7: A counted instruction at all-ones with level at or above `DBG_LEVEL` raises no request, but the counter still wraps to 0.
- R8: A counter write in the same cycle as a counted instruction wins: the written value is loaded and the increment is dropped.
- R9: Without a valid instruction or a write, the counter holds and `req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = counter, 1 = threshold |
| wr_data_i | input | 32 | Write data |
| insn_valid_i | input | 1 | Instruction about to execute |
| insn_level_i | input | 4 | Current interrupt level |
| req_o | output | 1 | Debug request for the current instruction |
| count_o | output | 32 | Current counter value |

## Verification
A corrupted counter shows on `count_o` one edge after the step that caused it. A bad threshold shows as a counter that moves, or fails to move, on the next counted instruction. An off-by-one in the overflow compare shows as `req_o` firing one instruction early or late. Each of these faults therefore appears within one or two cycles of the stimulus that exposes it.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  parameter int unsigned CNT_W     = 32;
  parameter int unsigned LVL_W     = 4;
  parameter int unsigned DBG_LEVEL = 6;

  typedef enum logic {
    SEL_COUNT  = 1'b0,
    SEL_THRESH = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/icnt_gate.sv
module icnt_gate #(
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned DBG_LEVEL = 6
) (
  input  logic             valid_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             count_o,
  output logic             dbg_ok_o
);
  localparam logic [LVL_W-1:0] DbgLvl = LVL_W'(DBG_LEVEL);

  assign count_o  = valid_i && (level_i < thresh_i);
  assign dbg_ok_o = level_i < DbgLvl;
endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;          // write beats increment
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);   // wraps at all-ones
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned LW  = LVL_W,
  parameter int unsigned DBG = DBG_LEVEL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          insn_valid_i,
  input  logic [LW-1:0] insn_level_i,
  output logic          req_o,
  output logic [CW-1:0] count_o
);
  logic [LW-1:0] thresh_q;
  logic          counted, dbg_ok, at_max;
  logic          cnt_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thresh_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_THRESH) thresh_q <= wr_data_i[LW-1:0];
  end

  assign cnt_load = wr_en_i && (wr_sel_i == SEL_COUNT);

  icnt_gate #(.LVL_W(LW), .DBG_LEVEL(DBG)) u_gate (
    .valid_i  (insn_valid_i),
    .level_i  (insn_level_i),
    .thresh_i (thresh_q),
    .count_o  (counted),
    .dbg_ok_o (dbg_ok)
  );

  icnt_counter #(.CNT_W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (wr_data_i),
    .inc_i      (counted),
    .cnt_o      (count_o),
    .at_max_o   (at_max)
  );

  assign req_o = counted && at_max && dbg_ok;
endmodule

// File: rtl/icnt_trigger_chk.sv
module icnt_trigger_chk #(
  parameter int unsigned CW  = 32,
  parameter int unsigned LW  = 4,
  parameter int unsigned DBG = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          wr_sel_i,
  input logic [CW-1:0] wr_data_i,
  input logic          insn_valid_i,
  input logic [LW-1:0] insn_level_i,
  input logic          req_o,
  input logic [CW-1:0] count_o,
  input logic [LW-1:0] thresh_q
);
  p_req_at_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (insn_valid_i && (&count_o) && insn_level_i < LW'(DBG)));

  p_req_below_thresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> insn_level_i < thresh_q);

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !wr_en_i) |=> count_o == '0);

  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> count_o == $past(wr_data_i));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!insn_valid_i && !wr_en_i) |=> $stable(count_o));

  p_idle_noreq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |-> !req_o);
endmodule

bind icnt_trigger icnt_trigger_chk #(.CW(CW), .LW(LW), .DBG(DBG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .insn_valid_i (insn_valid_i),
  .insn_level_i (insn_level_i),
  .req_o        (req_o),
  .count_o      (count_o),
  .thresh_q     (thresh_q)
);

// File: tb/icnt_trigger_tb.sv
module icnt_trigger_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic        we;
    logic        sel;
    logic [31:0] d;
    logic        v;
    logic [3:0]  lvl;
    logic        er;
    logic [31:0] ec;
    logic [7:0]  rq;
  } vec_t;

  // we sel data valid lvl | exp_req exp_count_after | requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,32'h0,1'b1,4'd0, 1'b0,32'h0,        8'd3}, // R3 thresh 0 counts nothing
    '{1'b1,1'b1,32'h1,1'b0,4'd0, 1'b0,32'h0,        8'd2}, // R2 thresh=1
    '{1'b1,1'b0,32'hFFFF_FFFE,1'b0,4'd0, 1'b0,32'hFFFF_FFFE, 8'd2}, // R2 count=-2
    '{1'b0,1'b0,32'h0,1'b1,4'd1, 1'b0,32'hFFFF_FFFE, 8'd4}, // R4 level==thresh
    '{1'b0,1'b0,32'h0,1'b1,4'd0, 1'b0,32'hFFFF_FFFF, 8'd3}, // R3 -2 -> -1
    '{1'b0,1'b0,32'h0,1'b0,4'd0, 1'b0,32'hFFFF_FFFF, 8'd9}, // R9 idle
    '{1'b0,1'b0,32'h0,1'b1,4'd0, 1'b1,32'h0,        8'd5}, // R5 R6 fire and wrap
    '{1'b1,1'b1,32'h8,1'b0,4'd0, 1'b0,32'h0,        8'd2}, // R2 thresh=8
    '{1'b1,1'b0,32'hFFFF_FFFF,1'b0,4'd0, 1'b0,32'hFFFF_FFFF, 8'd2},
    '{1'b0,1'b0,32'h0,1'b1,4'd6, 1'b0,32'h0,        8'd7}, // R7 debug gate blocks
    '{1'b1,1'b0,32'h5,1'b1,4'd0, 1'b0,32'h5,        8'd8}, // R8 write wins
    '{1'b0,1'b0,32'h0,1'b1,4'd7, 1'b0,32'h6,        8'd3}, // R3 level 7 < 8
    '{1'b0,1'b0,32'h0,1'b1,4'd9, 1'b0,32'h6,        8'd4}, // R4 above thresh
    '{1'b1,1'b0,32'hFFFF_FFFF,1'b0,4'd0, 1'b0,32'hFFFF_FFFF, 8'd2},
    '{1'b0,1'b0,32'h0,1'b1,4'd8, 1'b0,32'hFFFF_FFFF, 8'd4}, // R4 no req at thresh
    '{1'b0,1'b0,32'h0,1'b1,4'd5, 1'b1,32'h0,        8'd5}  // R5 level 5 fires
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, insn_valid_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  insn_level_i = '0;
  logic        req_o;
  logic [31:0] count_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  icnt_trigger u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .insn_valid_i(insn_valid_i), .insn_level_i(insn_level_i),
    .req_o(req_o), .count_o(count_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic sel, input logic [31:0] d,
                      input logic v, input logic [3:0] lvl,
                      input logic er, input logic [31:0] ec, input string tag);
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; insn_valid_i = v; insn_level_i = lvl;
    #(CLK_PERIOD/4);
    check({tag, " req"}, {31'b0, req_o}, {31'b0, er});
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; insn_valid_i = 1'b0;
    check({tag, " count"}, count_o, ec);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 reset count", count_o, 32'h0);
    check("R1 reset req", {31'b0, req_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      step(VEC[i].we, VEC[i].sel, VEC[i].d, VEC[i].v, VEC[i].lvl,
           VEC[i].er, VEC[i].ec, $sformatf("R%0d vec%0d", VEC[i].rq, i));
    // R1: reset mid-run clears counter and threshold
    step(1'b1, 1'b0, 32'h1234, 1'b0, 4'd0, 1'b0, 32'h1234, "R2 load");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset count", count_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 32'h0, 1'b1, 4'd0, 1'b0, 32'h0, "R1 thresh cleared");
    // R3: threshold uses only low bits (0x13 -> 3)
    step(1'b1, 1'b1, 32'h13, 1'b0, 4'd0, 1'b0, 32'h0, "R2 thresh low bits");
    step(1'b0, 1'b0, 32'h0, 1'b1, 4'd2, 1'b0, 32'h1, "R3 level 2 < 3");
    step(1'b0, 1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 32'h1, "R4 level 3 == 3");
    // R8: write of all-ones alongside counted insn: no request from old value
    step(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'd0, 1'b0, 32'hFFFF_FFFF, "R8 write with insn");
    step(1'b0, 1'b0, 32'h0, 1'b1, 4'd1, 1'b1, 32'h0, "R6 fire after write");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 2000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule